// File: doc/BRIEF.md
# DMA Address Watchpoint with Precise Stop

This block sits beside an audio DMA engine and watches the working address the engine reports. Several independent watch levels (two by default) each hold a threshold address. When a level is enabled and a valid working address lands in that level's 1 KB threshold window, the level's sticky flag goes high. The interrupt line is the OR of all flags whose level is enabled.

Each level can also halt the transfer. With its stop option set, a hit clears the DMA run bit on the same clock edge that sets the flag. Software then sees a stopped engine and a flag that names the level that stopped it. A register port gives access to one control word (run bit, level enables, write-one-to-clear flags) and to one threshold register per level. A threshold written outside the permitted memory region is kept, but that level is disarmed until a valid threshold is written.

Top module: `dma_watchpoint`

## Requirements
- R1: After reset the control word and all threshold registers read 0, `dma_en` is 0 and `irq` is 0.
- R2: A level compares only on cycles when `dma_addr_vld` is 1 and that level's enable bit (control bit 1+i for level i) is 1; otherwise its flag does not set.
- R3: A level hits when `dma_addr[31:10]` equals its threshold bits [31:10], so any address in that 1 KB window matches and addresses outside it do not. The flag (control bit 8+i) reads 1 from the cycle after the hit.
- R4: Threshold register i sits at register address 1+i. It keeps the compare address in [31:10] and the stop option in [0]. Bits [9:1] always read 0, whatever was written to them.
- R5: A hit on a level whose stop bit is 0 sets the flag and leaves `dma_en` unchanged.
- R6: A hit on a level whose stop bit is 1 makes `dma_en` read 0 in the same cycle that the flag reads 1. This wins over a control write of run=1 in the same cycle.
- R7: When both levels hit on the same cycle, both flags set, and a stop from either level clears `dma_en`.
- R8: Flags are sticky. Writing the control word (address 0) with bit 8+i set clears flag i. A hit in the same cycle as the clear keeps the flag set.
- R9: `irq` is 1 exactly when some flag is set and its level is enabled. Disabling a level masks its flag but does not clear it.
- R10: A threshold whose value, with [9:0] taken as zero, lies outside 0xC000_0000 to 0xC01F_FFFF never matches. The bounds 0xC000_0000 and 0xC01F_FC00 themselves are valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address: 0 control, 1+i threshold of level i |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from reg_addr |
| dma_addr_vld | input | 1 | Working address is valid this cycle |
| dma_addr | input | 32 | DMA working address |
| dma_en | output | 1 | DMA run enable (control bit 0) |
| irq | output | 1 | Interrupt, OR of enabled flags |

## Verification
The compare is driven with addresses at the start, middle and last word of a threshold window. It is also driven with the word just below the window, to tell a window match apart from an exact or off-by-one match. Hits are applied with the strobe low, with the level disabled, with the stop option both clear and set, and with both levels hit at once. These patterns separate gating by valid and by enable, the stop path and the flag path. Collisions of a hit with a flag clear and with a run write expose priority errors. Thresholds just outside and just inside the permitted region check the range test. A random stretch checked against a reference model every clock covers mixtures of these cases.

// File: rtl/dw_pkg.sv
package dw_pkg;
   // control word layout
   localparam int unsigned CTL_RUN_BIT   = 0;
   localparam int unsigned CTL_EN_BASE   = 1;
   localparam int unsigned CTL_FLAG_BASE = 8;
   localparam int unsigned MAX_LVL       = 7;

   typedef enum logic [1:0] {
      ACC_NONE = 2'd0,
      ACC_CTL  = 2'd1,
      ACC_THR  = 2'd2
   } acc_kind_e;
endpackage

// File: rtl/dw_cmp.sv
module dw_cmp #(
   parameter int unsigned AW  = 32,
   parameter int unsigned LSB = 10
) (
   input  logic [AW-1:0]     addr_i,
   input  logic [AW-LSB-1:0] ref_i,
   output logic              eq_o
);
   generate
      if (LSB == 0) begin : g_full
         assign eq_o = (addr_i == ref_i);
      end else begin : g_window
         logic [LSB-1:0] unused_low;
         assign unused_low = addr_i[LSB-1:0];
         assign eq_o = (addr_i[AW-1:LSB] == ref_i);
      end
   endgenerate
endmodule

// File: rtl/dw_level.sv
module dw_level #(
   parameter int unsigned AW       = 32,
   parameter int unsigned LSB      = 10,
   parameter logic [AW-1:0] WIN_LO = 32'hC000_0000,
   parameter logic [AW-1:0] WIN_HI = 32'hC01F_FFFF
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              thr_we,
   input  logic [AW-LSB-1:0] wr_addr,
   input  logic              wr_stop,
   input  logic              clr_flag,
   input  logic              lvl_en,
   input  logic              addr_vld,
   input  logic [AW-1:0]     addr,
   output logic              hit,
   output logic              stop_hit,
   output logic              flag,
   output logic [AW-1:0]     rdata
);
   logic [AW-LSB-1:0] thr_q;
   logic              stop_q;
   logic              ok_q;
   logic              flag_q;
   logic              eq;
   logic [AW-1:0]     wr_base;
   logic              wr_ok;

   assign wr_base = {wr_addr, {LSB{1'b0}}};
   assign wr_ok   = (wr_base >= WIN_LO) && (wr_base <= WIN_HI);

   dw_cmp #(.AW(AW), .LSB(LSB)) u_cmp (
      .addr_i (addr),
      .ref_i  (thr_q),
      .eq_o   (eq)
   );

   assign hit      = addr_vld && lvl_en && ok_q && eq;
   assign stop_hit = hit && stop_q;
   assign flag     = flag_q;
   assign rdata    = {thr_q, {(LSB-1){1'b0}}, stop_q};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         thr_q  <= '0;
         stop_q <= 1'b0;
         ok_q   <= 1'b0;
      end else if (thr_we) begin
         thr_q  <= wr_addr;
         stop_q <= wr_stop;
         ok_q   <= wr_ok;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        flag_q <= 1'b0;
      else if (hit)      flag_q <= 1'b1;
      else if (clr_flag) flag_q <= 1'b0;
   end

   AST_FLAG_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flag_q) |-> $past(addr_vld && lvl_en && eq)); // R3
   AST_IDLE_NO_SET: assert property (@(posedge clk) disable iff (!rst_n)
      (!(addr_vld && lvl_en) && !flag_q) |=> !flag_q); // R2
   AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_q && !clr_flag) |=> flag_q); // R8
   AST_BAD_THR_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
      (!ok_q && !thr_we && !flag_q) |=> !flag_q); // R10
endmodule

// File: rtl/dma_watchpoint.sv
module dma_watchpoint #(
   parameter int unsigned AW       = 32,
   parameter int unsigned CMP_LSB  = 10,
   parameter int unsigned NUM_LVL  = 2,
   parameter logic [AW-1:0] WIN_LO = 32'hC000_0000,
   parameter logic [AW-1:0] WIN_HI = 32'hC01F_FFFF,
   localparam int unsigned RA_W    = $clog2(NUM_LVL + 1)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            reg_we,
   input  logic [RA_W-1:0] reg_addr,
   input  logic [AW-1:0]   reg_wdata,
   output logic [AW-1:0]   reg_rdata,
   input  logic            dma_addr_vld,
   input  logic [AW-1:0]   dma_addr,
   output logic            dma_en,
   output logic            irq
);
   import dw_pkg::*;

   generate
      if (NUM_LVL < 1 || NUM_LVL > MAX_LVL) begin : g_bad_lvl
         $error("NUM_LVL out of range");
      end
      if (CMP_LSB < 2 || CMP_LSB >= AW) begin : g_bad_lsb
         $error("CMP_LSB out of range");
      end
      if (AW <= CTL_FLAG_BASE + MAX_LVL) begin : g_bad_aw
         $error("AW too narrow for control word");
      end
      if (WIN_LO > WIN_HI) begin : g_bad_win
         $error("WIN_LO above WIN_HI");
      end
   endgenerate

   logic               ctl_we;
   logic               run_q;
   logic [NUM_LVL-1:0] en_q;
   logic [NUM_LVL-1:0] hit;
   logic [NUM_LVL-1:0] stop_hit;
   logic [NUM_LVL-1:0] flag;
   logic [NUM_LVL-1:0] clr;
   logic [AW-1:0]      lvl_rd [NUM_LVL];
   acc_kind_e          acc;

   assign ctl_we = reg_we && (reg_addr == '0);

   generate
      for (genvar i = 0; i < NUM_LVL; i++) begin : g_lvl
         logic thr_we_i;
         assign thr_we_i = reg_we && (reg_addr == RA_W'(i + 1));
         assign clr[i]   = ctl_we && reg_wdata[CTL_FLAG_BASE + i];

         dw_level #(
            .AW(AW), .LSB(CMP_LSB), .WIN_LO(WIN_LO), .WIN_HI(WIN_HI)
         ) u_lvl (
            .clk      (clk),
            .rst_n    (rst_n),
            .thr_we   (thr_we_i),
            .wr_addr  (reg_wdata[AW-1:CMP_LSB]),
            .wr_stop  (reg_wdata[0]),
            .clr_flag (clr[i]),
            .lvl_en   (en_q[i]),
            .addr_vld (dma_addr_vld),
            .addr     (dma_addr),
            .hit      (hit[i]),
            .stop_hit (stop_hit[i]),
            .flag     (flag[i]),
            .rdata    (lvl_rd[i])
         );
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_q <= 1'b0;
         en_q  <= '0;
      end else begin
         if (ctl_we) begin
            run_q <= reg_wdata[CTL_RUN_BIT];
            en_q  <= reg_wdata[CTL_EN_BASE +: NUM_LVL];
         end
         if (|stop_hit) run_q <= 1'b0;
      end
   end

   always_comb begin
      acc = ACC_NONE;
      if (reg_addr == '0)                     acc = ACC_CTL;
      else if (int'(reg_addr) <= int'(NUM_LVL)) acc = ACC_THR;
   end

   always_comb begin
      reg_rdata = '0;
      case (acc)
         ACC_CTL: begin
            reg_rdata[CTL_RUN_BIT]              = run_q;
            reg_rdata[CTL_EN_BASE +: NUM_LVL]   = en_q;
            reg_rdata[CTL_FLAG_BASE +: NUM_LVL] = flag;
         end
         ACC_THR: begin
            for (int i = 0; i < NUM_LVL; i++) begin
               if (reg_addr == RA_W'(i + 1)) reg_rdata = lvl_rd[i];
            end
         end
         default: reg_rdata = '0;
      endcase
   end

   assign dma_en = run_q;
   assign irq    = |(flag & en_q);

   AST_STOP_HALTS: assert property (@(posedge clk) disable iff (!rst_n)
      (|stop_hit) |=> !dma_en); // R6
   AST_PLAIN_HIT_RUNS: assert property (@(posedge clk) disable iff (!rst_n)
      (dma_en && !(|stop_hit) && !ctl_we) |=> dma_en); // R5
   AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> (flag != '0)); // R9
   AST_ALL_HITS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      (hit != '0) |=> ((flag & $past(hit)) == $past(hit))); // R7
endmodule

// File: tb/dma_watchpoint_tb.sv
`timescale 1ns/100ps
module dma_watchpoint_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_we = 1'b0;
   logic [1:0]  reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        dma_addr_vld = 1'b0;
   logic [31:0] dma_addr = '0;
   logic        dma_en;
   logic        irq;

   int total = 0;
   int bad = 0;
   bit done = 0;

   always #2 clk = ~clk;

   dma_watchpoint u_dut (
      .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .dma_addr_vld(dma_addr_vld), .dma_addr(dma_addr),
      .dma_en(dma_en), .irq(irq)
   );

   // behavioural reference model
   bit        m_run;
   bit [1:0]  m_en, m_flag, m_ok, h;
   bit [31:0] m_thr [2];
   bit        stp;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_run = 0; m_en = 0; m_flag = 0; m_ok = 0;
         m_thr[0] = 0; m_thr[1] = 0;
      end else begin
         stp = 0;
         for (int i = 0; i < 2; i++) begin
            h[i] = dma_addr_vld && m_en[i] && m_ok[i] &&
                   (dma_addr[31:10] == m_thr[i][31:10]);
            if (h[i] && m_thr[i][0]) stp = 1;
         end
         if (reg_we && reg_addr == 0) begin
            m_run  = reg_wdata[0];
            m_en   = reg_wdata[2:1];
            m_flag = m_flag & ~reg_wdata[9:8];
         end
         for (int i = 0; i < 2; i++) begin
            if (reg_we && reg_addr == i + 1) begin
               m_thr[i] = {reg_wdata[31:10], 9'b0, reg_wdata[0]};
               m_ok[i]  = ({reg_wdata[31:10], 10'b0} >= 32'hC000_0000) &&
                          ({reg_wdata[31:10], 10'b0} <= 32'hC01F_FFFF);
            end
         end
         m_flag = m_flag | h;
         if (stp) m_run = 0;
      end
   end

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   always @(negedge clk) begin
      if (rst_n && !done) begin
         check("R6 dma_en vs model", {31'b0, dma_en}, {31'b0, m_run});
         check("R9 irq vs model", {31'b0, irq}, {31'b0, |(m_flag & m_en)});
      end
   end

   task automatic step; @(posedge clk); #1; endtask

   task automatic wr(input logic [1:0] a, input logic [31:0] d);
      reg_we = 1; reg_addr = a; reg_wdata = d;
      step();
      reg_we = 0;
   endtask

   task automatic beat(input logic [31:0] a);
      dma_addr_vld = 1; dma_addr = a;
      step();
      dma_addr_vld = 0;
   endtask

   task automatic wr_beat(input logic [1:0] ra, input logic [31:0] d, input logic [31:0] a);
      reg_we = 1; reg_addr = ra; reg_wdata = d;
      dma_addr_vld = 1; dma_addr = a;
      step();
      reg_we = 0; dma_addr_vld = 0;
   endtask

   task automatic rd(input logic [1:0] a, output logic [31:0] d);
      reg_addr = a; #0.5; d = reg_rdata;
   endtask

   initial begin
      #(4 * 100000);
      total++; bad++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      logic [31:0] v;
      repeat (3) @(posedge clk);
      #1 rst_n = 1;
      // R1 reset state
      rd(0, v); check("R1 ctrl", v, 32'h0);
      rd(1, v); check("R1 thr1", v, 32'h0);
      rd(2, v); check("R1 thr2", v, 32'h0);
      check("R1 dma_en", {31'b0, dma_en}, 0);
      check("R1 irq", {31'b0, irq}, 0);
      // R4 layout
      wr(1, 32'hC000_13FE); rd(1, v); check("R4 reserved zero", v, 32'hC000_1000);
      wr(1, 32'hC000_13FF); rd(1, v); check("R4 stop bit", v, 32'hC000_1001);
      wr(1, 32'hC000_1000);
      wr(0, 32'h1); check("R1 run set", {31'b0, dma_en}, 1);
      // R2 level disabled
      beat(32'hC000_1200); rd(0, v); check("R2 disabled level", v, 32'h1);
      wr(0, 32'h3);
      dma_addr = 32'hC000_1200; step(); rd(0, v); check("R2 strobe low", v, 32'h3);
      // R3 / R5 window hit at top word
      beat(32'hC000_13FC); rd(0, v); check("R3 flag set", v, 32'h103);
      check("R9 irq up", {31'b0, irq}, 1);
      check("R5 run kept", {31'b0, dma_en}, 1);
      // R9 masking
      wr(0, 32'h1); rd(0, v); check("R9 flag kept when masked", v, 32'h101);
      check("R9 irq masked", {31'b0, irq}, 0);
      // R8 clear
      wr(0, 32'h103); rd(0, v); check("R8 w1c", v, 32'h3);
      // R3 word just below window
      beat(32'hC000_0FFC); rd(0, v); check("R3 outside window", v, 32'h3);
      // R6 stop
      wr(2, 32'hC000_2001); wr(0, 32'h7);
      beat(32'hC000_23FC); rd(0, v); check("R6 stop flag", v, 32'h206);
      check("R6 dma halted", {31'b0, dma_en}, 0);
      // R7 both levels
      wr(1, 32'hC000_4000); wr(2, 32'hC000_4001); wr(0, 32'h307);
      rd(0, v); check("R8 clear both", v, 32'h7);
      beat(32'hC000_4004); rd(0, v); check("R7 both flags", v, 32'h306);
      // R6/R8 collisions
      wr_beat(0, 32'h307, 32'hC000_4000); rd(0, v); check("R6 R8 hit beats write", v, 32'h306);
      // R10 range
      wr(1, 32'hC020_0000); wr(0, 32'h307); rd(0, v); check("R8 clear again", v, 32'h7);
      beat(32'hC020_0000); rd(0, v); check("R10 above range", v, 32'h7);
      wr(1, 32'hBFFF_FC00); beat(32'hBFFF_FC00); rd(0, v); check("R10 below range", v, 32'h7);
      wr(1, 32'hC01F_FC00); beat(32'hC01F_FFFF); rd(0, v); check("R10 top bound valid", v, 32'h107);
      wr(1, 32'hC000_0000); wr(0, 32'h107); beat(32'hC000_0010); rd(0, v);
      check("R10 low bound valid", v, 32'h107);
      // random stretch against model
      for (int n = 0; n < 400; n++) begin
         int unsigned r;
         logic [31:0] cand;
         r = $urandom;
         cand = (r[5:4] == 0) ? 32'hC000_4000 : (r[5:4] == 1) ? 32'hC000_6000 :
                (r[5:4] == 2) ? 32'hC020_4000 : 32'hC01F_FC00;
         reg_we = r[0] && r[1];
         reg_addr = r[9:8];
         reg_wdata = (r[9:8] == 0) ? {22'b0, r[13:12], 5'b0, r[15:14], 1'b1} :
                     (cand | {31'b0, r[16]});
         dma_addr_vld = r[2];
         dma_addr = (r[3] ? cand : 32'hC000_4000) + {22'b0, r[27:20], 2'b0};
         step();
         reg_we = 0; dma_addr_vld = 0;
         if (!done) begin
            rd(0, v);
            check("R3 R8 ctrl vs model", v, {22'b0, m_flag, 5'b0, m_en, m_run});
         end
      end
      step();
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule